// File: doc/BRIEF.md
# Contact Image Sensor Line Timing Generator

This block produces the timing for a chain of contact image sensor chips that are read out as one line. It divides the system clock into a pixel clock with equal high and low halves. It issues a start pulse that opens each line. It then counts pixel clock periods, so that it can mark the active video window for an external sampling converter with a valid strobe and a pixel index.

Each line begins with the start-pulse period. A fixed run of dummy pixel periods follows, which also covers the photosite transfer time. The active pixels come after that. The number of active pixels depends on the resolution mode. Software sets the line length in pixel clocks. The block raises a short line length to the minimum that the chosen mode needs, and it raises a flag for a line length beyond the leakage limit. The resolution select and the line length are captured only at a line boundary, so one line always uses a single setting.

Top module: `cis_line_gen`

## Requirements
- R1: After reset, `res_ctl` and `len_over` are 0. While `en` is low, `pclk`, `sp`, `pix_vld` and `line_done` are 0 and `pix_idx` is 0.
- R2: While enabled, every high phase and every low phase of `pclk` lasts HALF_DIV system clock cycles.
- R3: `sp` changes only in the cycle in which `pclk` falls. It stays high for exactly one pixel period (2*HALF_DIV system cycles). The first `pclk` fall after `en` rises opens a line with `sp` high.
- R4: Counting the `sp` period as position 0, positions 1 to DUMMY are dummy pixels. `pix_vld` first rises at position DUMMY+1. DUMMY is at least the photosite transfer count XFER.
- R5: The active window lasts CHIPS*PIX_CHIP_HI pixel periods when the line was started with `res_hi`=1, and CHIPS*PIX_CHIP_LO pixel periods when it was started with `res_hi`=0. `pix_idx` starts at 0 and rises by 1 on each pixel period of the window.
- R6: The line period, counted in pixel clocks from one rise of `sp` to the next, equals the larger of `line_len` and the active count of the mode plus MARGIN.
- R7: `len_over` is 1 for a line whose captured `line_len` is greater than MAX_LEN. Such a line length is not shortened.
- R8: `res_hi` and `line_len` are captured in the cycle in which `sp` rises. Changes at any other time do not affect the current line. `res_ctl` shows the captured mode (1 = high resolution) and changes only when `sp` rises.
- R9: `line_done` is a one-cycle pulse. It comes on the `pclk` fall that ends the last active pixel, which is position DUMMY+active+1, in the same cycle in which `pix_vld` falls.
- R10: `pix_vld` and `pix_idx` change only in the cycle in which `pclk` falls. `pix_idx` is 0 outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low stops and clears the line sequence |
| res_hi | input | 1 | Requested resolution, 1 = high |
| line_len | input | LEN_W | Requested line period in pixel clocks |
| pclk | output | 1 | Pixel clock to the sensor |
| sp | output | 1 | Line start pulse, one pixel period wide |
| res_ctl | output | 1 | Resolution level to the sensor, captured per line |
| pix_vld | output | 1 | High during active pixel periods |
| pix_idx | output | IDX_W | Active pixel index from 0 |
| line_done | output | 1 | One-cycle pulse after the last active pixel |
| len_over | output | 1 | Captured line length exceeds MAX_LEN |

## Verification
All pixel-domain results (`sp`, `pix_vld`, `pix_idx`, `line_done`, `res_ctl`, `len_over`) change on the same system edge on which `pclk` falls. They are therefore due with no extra cycle after that edge. Inputs take effect only at the next rise of `sp`. The monitor samples on the falling system edge and counts pixel positions from each `sp`. For every line it compares the measured period, the window start, the active count, the index run, the position of `line_done` and the captured flags against the entry that the driver queued when it set the inputs one line earlier. Between pixel clock falls it checks that nothing in the pixel domain moved.

// File: rtl/cis_tg_pkg.sv
package cis_tg_pkg;

   // resolution captured for a line; value is the level sent to the sensor
   typedef enum logic {
      RES_LOW  = 1'b0,
      RES_HIGH = 1'b1
   } res_mode_e;

   // shortest legal line for a given active count
   function automatic int unsigned line_floor(int unsigned act, int unsigned margin);
      return act + margin;
   endfunction

endpackage

// File: rtl/cis_pclk_gen.sv
module cis_pclk_gen #(
   parameter int unsigned HALF_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic pclk,
   output logic fall_stb
);

   logic half_end;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign half_end = 1'b1;
      end else begin : g_div
         localparam int unsigned CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!en || cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign half_end = (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pclk <= 1'b0;
      else if (!en)
         pclk <= 1'b0;
      else if (half_end)
         pclk <= ~pclk;
   end

   // the sensor samples on the rising edge; everything else moves on the fall
   assign fall_stb = en & half_end & pclk;

endmodule

// File: rtl/cis_line_seq.sv
module cis_line_seq
   import cis_tg_pkg::*;
#(
   parameter int unsigned ACT_HI  = 5160,
   parameter int unsigned ACT_LO  = 2580,
   parameter int unsigned MARGIN  = 150,
   parameter int unsigned MAX_LEN = 40000,
   parameter int unsigned LEN_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             fall_stb,
   input  logic             res_hi,
   input  logic [LEN_W-1:0] line_len,
   output logic             sp,
   output logic [LEN_W-1:0] pos,
   output res_mode_e        res_q,
   output logic             over_q
);

   localparam logic [LEN_W-1:0] FLOOR_HI = LEN_W'(line_floor(ACT_HI, MARGIN));
   localparam logic [LEN_W-1:0] FLOOR_LO = LEN_W'(line_floor(ACT_LO, MARGIN));
   localparam logic [LEN_W-1:0] LIMIT    = LEN_W'(MAX_LEN);

   logic [LEN_W-1:0] period_q;
   logic [LEN_W-1:0] floor_v;
   logic [LEN_W-1:0] eff_v;
   logic             running;
   logic             wrap;

   assign floor_v = res_hi ? FLOOR_HI : FLOOR_LO;
   assign eff_v   = (line_len < floor_v) ? floor_v : line_len;
   assign wrap    = !running || (pos == period_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         pos      <= '0;
         sp       <= 1'b0;
         period_q <= '0;
         res_q    <= RES_LOW;
         over_q   <= 1'b0;
      end else if (!en) begin
         running <= 1'b0;
         pos     <= '0;
         sp      <= 1'b0;
      end else if (fall_stb) begin
         if (wrap) begin
            running  <= 1'b1;
            pos      <= '0;
            sp       <= 1'b1;
            period_q <= eff_v;
            res_q    <= res_mode_e'(res_hi);
            over_q   <= (line_len > LIMIT);
         end else begin
            pos <= pos + 1'b1;
            sp  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cis_pix_win.sv
module cis_pix_win
   import cis_tg_pkg::*;
#(
   parameter int unsigned DUMMY  = 82,
   parameter int unsigned ACT_HI = 5160,
   parameter int unsigned ACT_LO = 2580,
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned IDX_W  = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_stb,
   input  logic [LEN_W-1:0] pos,
   input  res_mode_e        res_q,
   output logic             pix_vld,
   output logic [IDX_W-1:0] pix_idx,
   output logic             line_done
);

   localparam logic [LEN_W-1:0] FIRST   = LEN_W'(DUMMY + 1);
   localparam logic [LEN_W-1:0] LAST_HI = LEN_W'(DUMMY + ACT_HI);
   localparam logic [LEN_W-1:0] LAST_LO = LEN_W'(DUMMY + ACT_LO);

   logic [LEN_W-1:0] last_v;
   logic             in_win;

   assign last_v  = (res_q == RES_HIGH) ? LAST_HI : LAST_LO;
   assign in_win  = (pos >= FIRST) && (pos <= last_v);
   assign pix_vld = in_win;
   assign pix_idx = in_win ? IDX_W'(pos - FIRST) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_done <= 1'b0;
      else
         line_done <= fall_stb && (pos == last_v);
   end

endmodule

// File: rtl/cis_line_gen.sv
module cis_line_gen
   import cis_tg_pkg::*;
#(
   parameter int unsigned HALF_DIV    = 32,
   parameter int unsigned CHIPS       = 15,
   parameter int unsigned PIX_CHIP_HI = 344,
   parameter int unsigned PIX_CHIP_LO = 172,
   parameter int unsigned DUMMY       = 82,
   parameter int unsigned XFER        = 55,
   parameter int unsigned MARGIN      = 150,
   parameter int unsigned MAX_LEN     = 40000,
   parameter int unsigned LEN_W       = 16,
   localparam int unsigned ACT_HI     = CHIPS * PIX_CHIP_HI,
   localparam int unsigned ACT_LO     = CHIPS * PIX_CHIP_LO,
   localparam int unsigned IDX_W      = (ACT_HI > 1) ? $clog2(ACT_HI) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             res_hi,
   input  logic [LEN_W-1:0] line_len,
   output logic             pclk,
   output logic             sp,
   output logic             res_ctl,
   output logic             pix_vld,
   output logic [IDX_W-1:0] pix_idx,
   output logic             line_done,
   output logic             len_over
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (DUMMY < XFER) begin : g_bad_dummy
         $error("dummy run shorter than photosite transfer");
      end
      if (MARGIN <= DUMMY) begin : g_bad_margin
         $error("MARGIN must exceed DUMMY so the window ends inside the line");
      end
      if (PIX_CHIP_LO == 0 || PIX_CHIP_LO >= PIX_CHIP_HI) begin : g_bad_modes
         $error("low-resolution count must be nonzero and below the high count");
      end
      if (LEN_W > 30 || (ACT_HI + MARGIN) >= (1 << LEN_W) || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("LEN_W too narrow for line floor or limit");
      end
      if (IDX_W > LEN_W) begin : g_bad_idx
         $error("index wider than position counter");
      end
   endgenerate

   logic             pclk_fall;
   logic [LEN_W-1:0] pos;
   res_mode_e        res_q;
   logic             over_q;

   cis_pclk_gen #(
      .HALF_DIV (HALF_DIV)
   ) u_pclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .pclk     (pclk),
      .fall_stb (pclk_fall)
   );

   cis_line_seq #(
      .ACT_HI  (ACT_HI),
      .ACT_LO  (ACT_LO),
      .MARGIN  (MARGIN),
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .fall_stb (pclk_fall),
      .res_hi   (res_hi),
      .line_len (line_len),
      .sp       (sp),
      .pos      (pos),
      .res_q    (res_q),
      .over_q   (over_q)
   );

   cis_pix_win #(
      .DUMMY  (DUMMY),
      .ACT_HI (ACT_HI),
      .ACT_LO (ACT_LO),
      .LEN_W  (LEN_W),
      .IDX_W  (IDX_W)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_stb  (pclk_fall),
      .pos       (pos),
      .res_q     (res_q),
      .pix_vld   (pix_vld),
      .pix_idx   (pix_idx),
      .line_done (line_done)
   );

   assign res_ctl  = (res_q == RES_HIGH);
   assign len_over = over_q;

endmodule

// File: rtl/cis_line_gen_chk.sv
module cis_line_gen_chk #(
   parameter int unsigned HALF_DIV = 32,
   parameter int unsigned IDX_W    = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pclk,
   input logic             pclk_fall,
   input logic             sp,
   input logic             res_ctl,
   input logic             pix_vld,
   input logic [IDX_W-1:0] pix_idx,
   input logic             line_done,
   input logic             len_over
);

   localparam int unsigned PW = $clog2(HALF_DIV + 2) + 1;

   logic          pclk_d;
   logic          ph_ok;
   logic [PW-1:0] ph_cnt;

   // length of the pclk phase that just ended, counted in system cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pclk_d <= 1'b0;
         ph_ok  <= 1'b0;
         ph_cnt <= '0;
      end else begin
         pclk_d <= pclk;
         if (!en) begin
            ph_ok  <= 1'b0;
            ph_cnt <= '0;
         end else if (pclk != pclk_d) begin
            ph_ok  <= 1'b1;
            ph_cnt <= PW'(1);
         end else if (ph_cnt != '1) begin
            ph_cnt <= ph_cnt + 1'b1;
         end
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pclk && !sp && !pix_vld && !line_done));

   p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph_ok && (pclk != pclk_d)) |-> (ph_cnt == PW'(HALF_DIV)));

   p_sp_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sp) |-> ($past(pclk_fall) && $fell(pclk)));

   p_idx_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_vld) |-> (pix_idx == '0));

   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld && $past(pix_vld) && !$stable(pix_idx)) |-> (pix_idx == $past(pix_idx) + 1'b1));

   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(sp) |-> ($stable(res_ctl) && $stable(len_over)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> ($fell(pix_vld) && $past(pclk_fall)));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done);

   p_win_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$past(pclk_fall)) |-> ($stable(pix_vld) && $stable(pix_idx)));

endmodule

bind cis_line_gen cis_line_gen_chk #(
   .HALF_DIV (HALF_DIV),
   .IDX_W    (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .pclk      (pclk),
   .pclk_fall (pclk_fall),
   .sp        (sp),
   .res_ctl   (res_ctl),
   .pix_vld   (pix_vld),
   .pix_idx   (pix_idx),
   .line_done (line_done),
   .len_over  (len_over)
);

// File: tb/cis_line_gen_tb.sv
module cis_line_gen_tb;

   localparam int T_HALF   = 2;
   localparam int T_CHIPS  = 2;
   localparam int T_PHI    = 4;
   localparam int T_PLO    = 2;
   localparam int T_DUMMY  = 5;
   localparam int T_XFER   = 3;
   localparam int T_MARGIN = 10;
   localparam int T_MAX    = 40;
   localparam int T_LEN_W  = 8;
   localparam int T_ACT_HI = T_CHIPS * T_PHI;
   localparam int T_ACT_LO = T_CHIPS * T_PLO;
   localparam int T_IDX_W  = $clog2(T_ACT_HI);

   logic               clk = 1'b0;
   logic               rst_n;
   logic               en;
   logic               res_hi;
   logic [T_LEN_W-1:0] line_len;
   logic               pclk, sp, res_ctl, pix_vld, line_done, len_over;
   logic [T_IDX_W-1:0] pix_idx;

   always #2 clk = ~clk;

   cis_line_gen #(
      .HALF_DIV    (T_HALF),
      .CHIPS       (T_CHIPS),
      .PIX_CHIP_HI (T_PHI),
      .PIX_CHIP_LO (T_PLO),
      .DUMMY       (T_DUMMY),
      .XFER        (T_XFER),
      .MARGIN      (T_MARGIN),
      .MAX_LEN     (T_MAX),
      .LEN_W       (T_LEN_W)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .res_hi    (res_hi),
      .line_len  (line_len),
      .pclk      (pclk),
      .sp        (sp),
      .res_ctl   (res_ctl),
      .pix_vld   (pix_vld),
      .pix_idx   (pix_idx),
      .line_done (line_done),
      .len_over  (len_over)
   );

   typedef struct {
      int res;
      int period;
      int over;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad   = 0;
   bit done  = 0;
   event sp_ev;

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int act_of(int r);
      return (r != 0) ? T_ACT_HI : T_ACT_LO;
   endfunction

   function automatic int exp_period(int r, int len);
      int fl = act_of(r) + T_MARGIN;
      return (len < fl) ? fl : len;
   endfunction

   function automatic exp_t mk(int r, int len);
      exp_t e;
      e.res    = r;
      e.period = exp_period(r, len);
      e.over   = (len > T_MAX) ? 1 : 0;
      return e;
   endfunction

   // monitor state
   int   pclk_prev = 0, vld_prev = 0, idx_prev = 0, en_prev = 0;
   int   have_line = 0, ppos = 0, vcount = 0, first_v = -1, idx_bad = 0;
   int   sp_cyc = 0, done_cnt = 0, done_pos = -1, stable_bad = 0, duty_bad = 0;
   int   res_seen = 0, over_seen = 0, fresh = 1;
   int   high_run = 0, low_run = 0, low_ok = 0;
   exp_t cur;

   task automatic finish_line();
      int a = act_of(cur.res);
      chk("R6 line period", ppos + 1, cur.period);
      chk("R5 active count", vcount, a);
      chk("R4 first active position", first_v, T_DUMMY + 1);
      chk("R5 index sequence errors", idx_bad, 0);
      chk("R8 captured mode on res_ctl", res_seen, cur.res);
      chk("R7 over-limit flag", over_seen, cur.over);
      chk("R9 line_done count", done_cnt, 1);
      chk("R9 line_done position", done_pos, T_DUMMY + a + 1);
      chk("R3 start pulse length", sp_cyc, 2 * T_HALF);
      chk("R10 changes between pclk falls", stable_bad, 0);
      chk("R2 duty errors", duty_bad, 0);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (!en) begin
            have_line = 0;
            low_ok    = 0;
            high_run  = 0;
            low_run   = 0;
            fresh     = 1;
         end else begin
            // duty cycle bookkeeping (R2)
            if (pclk && !pclk_prev) begin
               if (low_ok && low_run != T_HALF) duty_bad++;
               high_run = 1;
            end else if (!pclk && pclk_prev) begin
               if (high_run != T_HALF) duty_bad++;
               low_run = 1;
               low_ok  = 1;
            end else if (pclk) begin
               high_run++;
            end else begin
               low_run++;
            end

            if (pclk_prev && !pclk) begin
               if (fresh) begin
                  chk("R3 first fall after enable opens a line", sp, 1);
                  fresh = 0;
               end
               if (sp) begin
                  if (have_line) finish_line();
                  if (q.size() > 0) begin
                     cur       = q.pop_front();
                     have_line = 1;
                  end else begin
                     have_line = 0;
                  end
                  ppos = 0; vcount = 0; first_v = -1; idx_bad = 0;
                  sp_cyc = 0; done_cnt = 0; done_pos = -1;
                  stable_bad = 0; duty_bad = 0;
                  res_seen = res_ctl; over_seen = len_over;
                  -> sp_ev;
               end else begin
                  ppos++;
               end
               if (have_line) begin
                  if (pix_vld) begin
                     if (first_v < 0) first_v = ppos;
                     if (int'(pix_idx) != vcount) idx_bad++;
                     vcount++;
                  end else if (pix_idx != 0) begin
                     idx_bad++;
                  end
               end
            end else if (have_line && en_prev != 0) begin
               if (int'(pix_vld) != vld_prev || int'(pix_idx) != idx_prev) stable_bad++;
            end

            if (have_line) begin
               if (sp) sp_cyc++;
               if (line_done) begin
                  done_cnt++;
                  done_pos = ppos;
               end
            end
         end
      end
      pclk_prev = pclk;
      vld_prev  = pix_vld;
      idx_prev  = pix_idx;
      en_prev   = en;
   end

   // driver: set the next line's inputs right after a line opens
   task automatic next_line(int r, int len);
      @(sp_ev);
      res_hi   = r[0];
      line_len = T_LEN_W'(len);
      q.push_back(mk(r, len));
   endtask

   task automatic idle_check(string when);
      chk({"R1 pclk low ", when}, pclk, 0);
      chk({"R1 sp low ", when}, sp, 0);
      chk({"R1 pix_vld low ", when}, pix_vld, 0);
      chk({"R1 line_done low ", when}, line_done, 0);
      chk({"R1 pix_idx zero ", when}, pix_idx, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; res_hi = 1'b0; line_len = '0;
      repeat (3) @(negedge clk);
      idle_check("in reset");
      chk("R1 res_ctl after reset", res_ctl, 0);
      chk("R1 len_over after reset", len_over, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      idle_check("enable low");

      // phase 1: clamp, exact floor, long and over-limit lines, mode swaps
      res_hi = 1'b1; line_len = '0;
      q.push_back(mk(1, 0));
      en = 1'b1;
      next_line(1, 25);
      next_line(0, 5);
      next_line(0, 14);
      next_line(0, 13);
      next_line(1, 17);
      next_line(1, 18);
      next_line(1, 19);
      next_line(1, 40);
      next_line(1, 41);
      next_line(0, 60);
      next_line(1, 18);
      @(sp_ev);
      // change settings mid-line of an unrecorded line: no record follows
      @(sp_ev);
      en = 1'b0;
      repeat (3) @(negedge clk);
      idle_check("after disable");

      // phase 2: restart from idle
      res_hi = 1'b0; line_len = T_LEN_W'(20);
      q.push_back(mk(0, 20));
      @(negedge clk);
      en = 1'b1;
      next_line(1, 30);
      @(sp_ev);
      @(sp_ev);
      en = 1'b0;
      repeat (3) @(negedge clk);
      idle_check("after second disable");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule